// File: doc/BRIEF.md
# Pipelined Complex Multiplier with Radix-4 Recoding

This block forms the full-precision product of two complex operands, (aRe + j·aIm)·(bRe + j·bIm), with 16-bit signed two's-complement components. The four real multiplications each use radix-4 digit recoding. This halves the number of rows that must be summed. The rows are compressed in carry-save form, and a single carry-propagate addition per product follows. The real part is the difference of two products and the imaginary part is their sum. The block takes a new operand pair on every clock and delivers one complete result on every clock, three clocks after capture. A qualifier bit moves through the pipeline alongside the data.

A built-in test mode substitutes operands generated by an on-chip shift-register sequence and compacts every test result into a signature register. A single read of that register after a run tells whether the datapath is healthy. Typical uses are filtering, mixing and rotating a sample vector by a unit-magnitude complex factor.

Top module: `cplx_booth_mul`

## Requirements
- R1: While reset is sampled high on a clock edge, that edge clears the qualifier in every pipeline stage, the signature register and the pattern generator (seed 16'hACE1). Immediately after reset, validOut is 0 and signature is 0.
- R2: validOut equals the effective input qualifier (validIn OR selfTest) as it was sampled three rising edges earlier. There is no other latency.
- R3: prodRe is the 33-bit signed value aRe·bRe − aIm·bIm of the operands captured three edges earlier. It is exact for every operand value, including −32768 in every component.
- R4: prodIm is the 33-bit signed value aRe·bIm + aIm·bRe of the operands captured three edges earlier. It is exact for every operand value.
- R5: Operands presented on consecutive clocks give results on consecutive clocks, in order and without gaps.
- R6: Multiplying by a rotation factor behaves as complex multiplication. Multiplying by j turns (x, y) into (−y, x). Multiplying by −1 gives (−x, −y).
- R7: While selfTest is high, the operand ports and validIn are ignored. Each edge uses the generator state L as aRe = L, aIm = ~L, bRe = {L[7:0], L[15:8]} and bIm = L ^ 16'h5A5A. The generator then steps to {L[14:0], L[15]^L[13]^L[12]^L[10]}. The generator holds its state while selfTest is low.
- R8: On each edge where validOut is high for a result that entered in test mode, the signature S becomes ({S[30:0],0} ^ (S[31] ? 32'h04C11DB7 : 0)) ^ prodRe[31:0] ^ {prodIm[15:0], prodIm[31:16]}. On every other edge the signature holds.
- R9: A reset that arrives while results are in flight drops them. validOut is 0 after the reset edge, and no stale result appears later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| selfTest | input | 1 | Use generated operands and compact results |
| validIn | input | 1 | Operands on the ports are meaningful |
| aRe | input | 16 | First operand, real part |
| aIm | input | 16 | First operand, imaginary part |
| bRe | input | 16 | Second operand, real part |
| bIm | input | 16 | Second operand, imaginary part |
| validOut | output | 1 | prodRe/prodIm hold a result |
| prodRe | output | 33 | Real part of product |
| prodIm | output | 33 | Imaginary part of product |
| signature | output | 32 | Compacted test-mode results |

## Verification
Two functions can act in the same cycle: the signature fold of the oldest test result, and a fresh result leaving the pipeline. A reset edge can also land while all three stages hold live results. The bench runs an uninterrupted test-mode burst so that every fold coincides with a new product. It then compares the final signature with a model built only from the pattern and fold rules in the requirements. It also fills the pipeline with tagged operands, applies reset on a single edge, and checks that none of those results ever surfaces.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  parameter int OPW = 16;
  localparam int PW = 2 * OPW;
  localparam int RW = PW + 1;
  localparam int NROW = OPW / 2;
  localparam int NPROD = 4;
  localparam int DEPTH = 3;
  localparam logic [OPW-1:0] SEED = 16'hACE1;
  localparam logic [OPW-1:0] TAPS = 16'hB400;
  localparam logic [OPW-1:0] MASKB = 16'h5A5A;
  localparam logic [PW-1:0] POLY = 32'h04C11DB7;

  typedef logic [OPW-1:0] op_t;
  typedef logic [PW-1:0] row_t;
  typedef logic [NROW-1:0][PW-1:0] rowSet_t;
  typedef struct packed { row_t sum; row_t carry; } pair_t;
  typedef struct packed { logic selPattern; op_t pattern; } ctrlStrobe_t;

  // Radix-4 recoding: one signed-digit row per pair of multiplier bits.
  function automatic rowSet_t boothRows(op_t m, op_t q);
    rowSet_t rows;
    logic [OPW:0] qx;
    row_t mExt;
    row_t r;
    qx = {q, 1'b0};
    mExt = {{OPW{m[OPW-1]}}, m};
    for (int i = 0; i < NROW; i++) begin
      case (qx[2*i+2 -: 3])
        3'b001, 3'b010: r = mExt;
        3'b011:         r = mExt << 1;
        3'b100:         r = -(mExt << 1);
        3'b101, 3'b110: r = -mExt;
        default:        r = '0;
      endcase
      rows[i] = r << (2 * i);
    end
    return rows;
  endfunction

  // Carry-save array: fold all rows into one sum/carry pair.
  function automatic pair_t csaReduce(rowSet_t rows);
    pair_t p;
    row_t ns;
    p.sum = rows[0];
    p.carry = rows[1];
    for (int i = 2; i < NROW; i++) begin
      ns = p.sum ^ p.carry ^ rows[i];
      p.carry = ((p.sum & p.carry) | (p.sum & rows[i]) | (p.carry & rows[i])) << 1;
      p.sum = ns;
    end
    return p;
  endfunction
endpackage

// File: rtl/cmul_ctrl.sv
module cmul_ctrl
  import cmul_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          selfTest,
  input  logic          validIn,
  input  logic [RW-1:0] prodRe,
  input  logic [RW-1:0] prodIm,
  output ctrlStrobe_t   strobe,
  output logic          validOut,
  output logic [PW-1:0] signature
);
  logic [DEPTH-1:0] vldPipe;
  logic [DEPTH-1:0] tagPipe;
  op_t lfsr;
  logic [PW-1:0] foldData;

  assign strobe.selPattern = selfTest;
  assign strobe.pattern = lfsr;
  assign validOut = vldPipe[DEPTH-1];
  assign foldData = prodRe[PW-1:0] ^ {prodIm[OPW-1:0], prodIm[PW-1:OPW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      vldPipe <= '0;
      tagPipe <= '0;
      lfsr <= SEED;
      signature <= '0;
    end else begin
      vldPipe <= {vldPipe[DEPTH-2:0], validIn | selfTest};
      tagPipe <= {tagPipe[DEPTH-2:0], selfTest};
      if (selfTest) lfsr <= {lfsr[OPW-2:0], ^(lfsr & TAPS)};
      if (vldPipe[DEPTH-1] && tagPipe[DEPTH-1])
        signature <= ({signature[PW-2:0], 1'b0} ^ (signature[PW-1] ? POLY : '0)) ^ foldData;
    end
  end
endmodule

// File: rtl/cmul_datapath.sv
module cmul_datapath
  import cmul_pkg::*;
(
  input  logic          clk,
  input  ctrlStrobe_t   strobe,
  input  op_t           aRe,
  input  op_t           aIm,
  input  op_t           bRe,
  input  op_t           bIm,
  output logic [RW-1:0] prodRe,
  output logic [RW-1:0] prodIm
);
  op_t opARe, opAIm, opBRe, opBIm;
  op_t mcand [NPROD];
  op_t mplier [NPROD];
  rowSet_t s1Rows [NPROD];
  pair_t s2Pair [NPROD];
  logic [RW-1:0] prodExt [NPROD];

  always_comb begin
    if (strobe.selPattern) begin
      opARe = strobe.pattern;
      opAIm = ~strobe.pattern;
      opBRe = {strobe.pattern[OPW/2-1:0], strobe.pattern[OPW-1:OPW/2]};
      opBIm = strobe.pattern ^ MASKB;
    end else begin
      opARe = aRe;
      opAIm = aIm;
      opBRe = bRe;
      opBIm = bIm;
    end
    // product order: ac, bd, ad, bc
    mcand[0] = opARe; mplier[0] = opBRe;
    mcand[1] = opAIm; mplier[1] = opBIm;
    mcand[2] = opARe; mplier[2] = opBIm;
    mcand[3] = opAIm; mplier[3] = opBRe;
  end

  for (genvar p = 0; p < NPROD; p++) begin : g_prod
    always_ff @(posedge clk) begin
      s1Rows[p] <= boothRows(mcand[p], mplier[p]);
      s2Pair[p] <= csaReduce(s1Rows[p]);
    end
    always_comb begin
      row_t full;
      full = s2Pair[p].sum + s2Pair[p].carry;
      prodExt[p] = {full[PW-1], full};
    end
  end

  always_ff @(posedge clk) begin
    prodRe <= prodExt[0] - prodExt[1];
    prodIm <= prodExt[2] + prodExt[3];
  end
endmodule

// File: rtl/cplx_booth_mul.sv
module cplx_booth_mul
  import cmul_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          selfTest,
  input  logic          validIn,
  input  logic [15:0]   aRe,
  input  logic [15:0]   aIm,
  input  logic [15:0]   bRe,
  input  logic [15:0]   bIm,
  output logic          validOut,
  output logic [32:0]   prodRe,
  output logic [32:0]   prodIm,
  output logic [31:0]   signature
);
  ctrlStrobe_t strobe;

  cmul_ctrl u_ctrl (
    .clk(clk), .rst(rst), .selfTest(selfTest), .validIn(validIn),
    .prodRe(prodRe), .prodIm(prodIm), .strobe(strobe),
    .validOut(validOut), .signature(signature)
  );

  cmul_datapath u_dp (
    .clk(clk), .strobe(strobe), .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm),
    .prodRe(prodRe), .prodIm(prodIm)
  );
endmodule

// File: rtl/cplx_booth_mul_chk.sv
module cplx_booth_mul_chk (
  input logic        clk,
  input logic        rst,
  input logic        selfTest,
  input logic        validIn,
  input logic [15:0] aRe,
  input logic [15:0] aIm,
  input logic [15:0] bRe,
  input logic [15:0] bIm,
  input logic        validOut,
  input logic [32:0] prodRe,
  input logic [32:0] prodIm,
  input logic [31:0] signature
);
  logic [1:0] age;
  logic signed [32:0] refRe, refIm;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  always_comb begin
    refRe = 33'($signed(aRe)) * 33'($signed(bRe)) - 33'($signed(aIm)) * 33'($signed(bIm));
    refIm = 33'($signed(aRe)) * 33'($signed(bIm)) + 33'($signed(aIm)) * 33'($signed(bRe));
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!validOut && signature == 32'd0));

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (validOut == $past(validIn | selfTest, 3)));

  // R3
  real_part_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && validOut && !$past(selfTest, 3)) |-> (prodRe == $past(refRe, 3)));

  // R4
  imag_part_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && validOut && !$past(selfTest, 3)) |-> (prodIm == $past(refIm, 3)));

  // R8
  signature_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !validOut |=> $stable(signature));
endmodule

bind cplx_booth_mul cplx_booth_mul_chk u_chk (
  .clk(clk), .rst(rst), .selfTest(selfTest), .validIn(validIn),
  .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm), .validOut(validOut),
  .prodRe(prodRe), .prodIm(prodIm), .signature(signature)
);

// File: tb/cplx_booth_mul_bench.sv
module cplx_booth_mul_bench;
  localparam int PERIOD = 10;
  localparam int NVEC = 8;
  localparam int NST = 24;
  // {aRe, aIm, bRe, bIm}
  localparam logic [63:0] VEC [NVEC] = '{
    {16'd3, 16'd4, 16'd5, 16'd6},
    {16'hFFFF, 16'd2, 16'd7, 16'hFFFD},
    {16'h8000, 16'h8000, 16'h8000, 16'h8000},
    {16'h8000, 16'h7FFF, 16'h8000, 16'h8000},
    {16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h8000},
    {16'h1234, 16'hABCD, 16'h5555, 16'hAAAA},
    {16'd0, 16'd0, 16'h7FFF, 16'h8000},
    {16'h00FF, 16'hFF00, 16'h0F0F, 16'hF0F0}
  };

  logic clk = 1'b0;
  logic rst, selfTest, validIn;
  logic [15:0] aRe, aIm, bRe, bIm;
  logic validOut;
  logic [32:0] prodRe, prodIm;
  logic [31:0] signature;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  cplx_booth_mul u_cplx_booth_mul (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic longint mulRe(logic [63:0] v);
    return longint'($signed(v[63:48])) * longint'($signed(v[31:16]))
         - longint'($signed(v[47:32])) * longint'($signed(v[15:0]));
  endfunction
  function automatic longint mulIm(logic [63:0] v);
    return longint'($signed(v[63:48])) * longint'($signed(v[15:0]))
         + longint'($signed(v[47:32])) * longint'($signed(v[31:16]));
  endfunction
  function automatic longint asLong(logic [32:0] x);
    return longint'($signed(x));
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [63:0] x);
    validIn = v;
    {aRe, aIm, bRe, bIm} = x;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    logic [15:0] lfsr;
    logic [31:0] sig;
    logic [63:0] pv;
    logic [31:0] d;
    longint pr, pi;
    rst = 1; selfTest = 0;
    drive(1'b0, 64'd0);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(validOut == 1'b0, "R1", validOut, 0);
    check(signature == 32'd0, "R1", signature, 0);

    // R3 R4 R5 table streamed back to back
    for (int k = 0; k < NVEC + 3; k++) begin
      if (k >= 3) begin
        check(validOut == 1'b1, "R5", validOut, 1);
        check(asLong(prodRe) == mulRe(VEC[k-3]), "R3", asLong(prodRe), mulRe(VEC[k-3]));
        check(asLong(prodIm) == mulIm(VEC[k-3]), "R4", asLong(prodIm), mulIm(VEC[k-3]));
      end
      if (k < NVEC) drive(1'b1, VEC[k]);
      else drive(1'b0, 64'd0);
      @(negedge clk);
    end
    check(validOut == 1'b0, "R2", validOut, 0);

    // R2 single isolated operand: exact latency
    drive(1'b1, {16'd10, 16'd20, 16'd30, 16'd40});
    @(negedge clk);
    drive(1'b0, 64'd0);
    @(negedge clk);
    check(validOut == 1'b0, "R2", validOut, 0);
    @(negedge clk);
    check(validOut == 1'b1, "R2", validOut, 1);
    check(asLong(prodRe) == -500, "R3", asLong(prodRe), -500);
    @(negedge clk);
    check(validOut == 1'b0, "R2", validOut, 0);

    // R6 rotation by j then by -1
    drive(1'b1, {16'd3000, 16'hF060, 16'd0, 16'd1});
    @(negedge clk);
    drive(1'b1, {16'd3000, 16'hF060, 16'hFFFF, 16'd0});
    @(negedge clk);
    drive(1'b0, 64'd0);
    @(negedge clk);
    check(asLong(prodRe) == 4000 && asLong(prodIm) == 3000, "R6", asLong(prodRe), 4000);
    @(negedge clk);
    check(asLong(prodRe) == -3000 && asLong(prodIm) == 4000, "R6", asLong(prodRe), -3000);

    // R9 reset with pipeline full
    drive(1'b1, VEC[0]);
    repeat (3) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    drive(1'b0, 64'd0);
    check(validOut == 1'b0, "R9", validOut, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(validOut == 1'b0, "R9", validOut, 0);
    end
    check(signature == 32'd0, "R1", signature, 0);

    // R7 R8 self-test burst; ports carry junk that must be ignored
    selfTest = 1;
    drive(1'b0, 64'hDEAD_BEEF_0BAD_F00D);
    lfsr = 16'hACE1;
    sig = 32'd0;
    for (int k = 0; k < NST; k++) begin
      pv = {lfsr, ~lfsr, {lfsr[7:0], lfsr[15:8]}, lfsr ^ 16'h5A5A};
      pr = mulRe(pv);
      pi = mulIm(pv);
      d = pr[31:0] ^ {pi[15:0], pi[31:16]};
      if (k == 0) begin
        repeat (3) @(negedge clk);
        check(validOut == 1'b1, "R7", validOut, 1);
        check(asLong(prodRe) == pr, "R7", asLong(prodRe), pr);
        check(asLong(prodIm) == pi, "R7", asLong(prodIm), pi);
      end
      sig = ({sig[30:0], 1'b0} ^ (sig[31] ? 32'h04C11DB7 : 32'd0)) ^ d;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    repeat (NST - 3) @(negedge clk);
    selfTest = 0;
    repeat (6) @(negedge clk);
    check(validOut == 1'b0, "R7", validOut, 0);
    check(signature == sig, "R8", signature, sig);
    // R8 signature holds for normal-mode results
    drive(1'b1, VEC[5]);
    @(negedge clk);
    drive(1'b0, 64'd0);
    repeat (5) @(negedge clk);
    check(signature == sig, "R8", signature, sig);
    summary();
  end
endmodule